// File: doc/BRIEF.md
# Write-Protected 12-bit PWM Timer with Complementary Dead-Time Outputs

This block generates a pulse-width-modulated waveform from a 12-bit period counter and a 12-bit duty comparator. It drives a main output and a second output. In the default pairing the second output is the inverse of the main one, and a programmable dead-time gap keeps both outputs inactive after every transition. A one-cycle interrupt pulse marks the end of each period. A clock-select input divides the system clock by 1, 2, 4 or 8 to form the PWM tick.

Software configures the block through a byte-wide write port. The 12-bit period and duty values are each split into a low byte and a high byte. Writing the high byte marks the pair as complete. The new value moves into the active comparator only at the next period boundary. Every register except the lock register is write-protected, and it accepts writes only while the lock register holds the key value 0x55. This keeps stray writes from changing a running waveform.

Top module: `pwm_lk_top`

## Requirements
- R1: After reset, pwm_a, pwm_b and period_irq are low, all registers are zero, the lock is closed and the timer is disabled.
- R2: Address 0 (lock) is always writable. Writes to addresses 1 to 6 are ignored unless the lock register holds 0x55.
- R3: The register map is 1 = control (bit 0 enable, bit 1 single-output mode), 2 = period low byte, 3 = period high nibble in data bits 3:0, 4 = duty low byte, 5 = duty high nibble in data bits 3:0, and 6 = dead time in ticks.
- R4: A staged period or duty value is not used until its high byte has been written. A low-byte write alone changes nothing at the outputs.
- R5: While enabled, a completed period or duty value becomes active only at the end of the current period. While disabled, it becomes active on the next clock.
- R6: The counter steps 0..P-1 on each tick, and a period of 0 behaves as one tick. period_irq pulses for one clock exactly once per period.
- R7: The undelayed PWM level is high while the counter is below the duty D. D = 0 gives a constant low level, and D >= P gives a constant high level.
- R8: In complementary mode (bit 1 = 0), each high run of length L drives pwm_a for max(L-DT,0) ticks and each low run drives pwm_b for max(L-DT,0) ticks. pwm_a and pwm_b are never high together.
- R9: In single-output mode (bit 1 = 1), pwm_a follows the undelayed level with no dead time and pwm_b stays low.
- R10: clk_sel = s gives one tick every 2^s clocks, so a period lasts P*2^s clocks.
- R11: While disabled, both outputs and period_irq stay low and the counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| clk_sel | input | SEL_W | Tick divider select, 2^clk_sel |
| pwm_a | output | 1 | Main PWM output |
| pwm_b | output | 1 | Complementary or idle second output |
| period_irq | output | 1 | One-clock pulse at each period end |

## Verification
The main function is driven from a table of period, duty, dead-time and divider settings. Each window of one full period is reduced to three counts: main-output high clocks, second-output high clocks and interrupt pulses. A mid-range duty separates correct dead-time subtraction from an off-by-one comparator. Duty values of zero and of at or above the period expose wrong constant-level handling. A duty shorter than the dead time shows that a run that is too short is suppressed. Periods above 255 exercise the high byte, and divided clocks tell the tick logic apart from the counter.

// File: rtl/pwm_lk_pkg.sv
package pwm_lk_pkg;
   localparam logic [7:0] UNLOCK_KEY = 8'h55;

   typedef enum logic [2:0] {
      A_LOCK    = 3'd0,
      A_CTRL    = 3'd1,
      A_PER_LO  = 3'd2,
      A_PER_HI  = 3'd3,
      A_DUTY_LO = 3'd4,
      A_DUTY_HI = 3'd5,
      A_DEAD    = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic single;
      logic enable;
   } ctrl_t;
endpackage

// File: rtl/pwm_lk_regs.sv
module pwm_lk_regs
   import pwm_lk_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int DT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             load,
   output ctrl_t            ctrl_q,
   output logic [CNT_W-1:0] per_stg,
   output logic             per_apply,
   output logic [CNT_W-1:0] duty_stg,
   output logic             duty_apply,
   output logic [DT_W-1:0]  dt_val,
   output logic             unlocked
);
   localparam int HI_W = CNT_W - 8;

   logic [7:0] lock_q;
   logic       wr_ok;
   logic       per_hi_wr, duty_hi_wr;
   logic       per_pend, duty_pend;

   assign unlocked   = (lock_q == UNLOCK_KEY);
   assign wr_ok      = wr_en & unlocked;
   assign per_hi_wr  = wr_ok && (wr_addr == A_PER_HI);
   assign duty_hi_wr = wr_ok && (wr_addr == A_DUTY_HI);
   // a high byte arriving in the same cycle defers the transfer
   assign per_apply  = per_pend & ~per_hi_wr;
   assign duty_apply = duty_pend & ~duty_hi_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q    <= '0;
         ctrl_q    <= '0;
         per_stg   <= '0;
         duty_stg  <= '0;
         dt_val    <= '0;
         per_pend  <= 1'b0;
         duty_pend <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == A_LOCK)) lock_q <= wr_data;
         if (wr_ok) begin
            case (wr_addr)
               A_CTRL:    ctrl_q               <= ctrl_t'(wr_data[1:0]);
               A_PER_LO:  per_stg[7:0]         <= wr_data;
               A_PER_HI:  per_stg[CNT_W-1:8]   <= wr_data[HI_W-1:0];
               A_DUTY_LO: duty_stg[7:0]        <= wr_data;
               A_DUTY_HI: duty_stg[CNT_W-1:8]  <= wr_data[HI_W-1:0];
               A_DEAD:    dt_val               <= wr_data[DT_W-1:0];
               default: ;
            endcase
         end
         if (per_hi_wr)                  per_pend  <= 1'b1;
         else if (load && per_pend)      per_pend  <= 1'b0;
         if (duty_hi_wr)                 duty_pend <= 1'b1;
         else if (load && duty_pend)     duty_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_lk_timebase.sv
module pwm_lk_timebase #(
   parameter int CNT_W = 12,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic [CNT_W-1:0] per_stg,
   input  logic             per_apply,
   input  logic [CNT_W-1:0] duty_stg,
   input  logic             duty_apply,
   output logic             tick,
   output logic             load,
   output logic             raw,
   output logic [CNT_W-1:0] per_act,
   output logic [CNT_W-1:0] duty_act,
   output logic             irq
);
   localparam int PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   always_comb begin
      mask = '0;
      for (int i = 0; i < PRE_W; i++)
         if (i < int'(clk_sel)) mask[i] = 1'b1;
   end

   assign tick = ((pre_q & mask) == mask);
   assign wrap = (per_act == '0) || (cnt_q == per_act - CNT_W'(1));
   assign load = enable ? (tick & wrap) : 1'b1;
   assign raw  = (cnt_q < duty_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q    <= '0;
         cnt_q    <= '0;
         per_act  <= '0;
         duty_act <= '0;
         irq      <= 1'b0;
      end else begin
         pre_q <= pre_q + PRE_W'(1);
         irq   <= enable & tick & wrap;
         if (!enable)   cnt_q <= '0;
         else if (tick) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
         if (load && per_apply)  per_act  <= per_stg;
         if (load && duty_apply) duty_act <= duty_stg;
      end
   end
endmodule

// File: rtl/pwm_lk_deadband.sv
module pwm_lk_deadband #(
   parameter int DT_W    = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            single,
   input  logic            tick,
   input  logic            raw,
   input  logic [DT_W-1:0] dt_val,
   output logic            pwm_a,
   output logic            pwm_b
);
   logic            raw_q;
   logic [DT_W-1:0] run_q;
   logic            settled;
   logic            a_n, b_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         run_q <= '1;
      end else if (!enable) begin
         raw_q <= 1'b0;
         run_q <= '1;
      end else if (tick) begin
         raw_q <= raw;
         if (raw != raw_q)    run_q <= '0;
         else if (run_q != '1) run_q <= run_q + DT_W'(1);
      end
   end

   assign settled = (run_q >= dt_val);
   assign a_n = enable & raw_q & (single | settled);
   assign b_n = enable & ~single & ~raw_q & settled;

   generate
      if (OUT_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pwm_a <= 1'b0;
               pwm_b <= 1'b0;
            end else begin
               pwm_a <= a_n;
               pwm_b <= b_n;
            end
         end
      end else begin : g_comb
         assign pwm_a = a_n;
         assign pwm_b = b_n;
      end
   endgenerate
endmodule

// File: rtl/pwm_lk_top.sv
module pwm_lk_top
   import pwm_lk_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int DT_W    = 8,
   parameter int SEL_W   = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [SEL_W-1:0] clk_sel,
   output logic             pwm_a,
   output logic             pwm_b,
   output logic             period_irq
);
   generate
      if (CNT_W <= 8 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must span one full byte plus a partial high byte");
      end
      if (DT_W < 1 || DT_W > 8) begin : g_bad_dt
         $error("DT_W must fit one byte");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("SEL_W out of range");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic             en_w, single_w;
   logic [CNT_W-1:0] per_stg, duty_stg, per_act, duty_act;
   logic             per_apply, duty_apply;
   logic [DT_W-1:0]  dt_val;
   logic             unlocked;
   logic             tick, load_req, raw;

   assign en_w     = ctrl_q.enable;
   assign single_w = ctrl_q.single;

   pwm_lk_regs #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(load_req), .ctrl_q(ctrl_q),
      .per_stg(per_stg), .per_apply(per_apply), .duty_stg(duty_stg),
      .duty_apply(duty_apply), .dt_val(dt_val), .unlocked(unlocked)
   );

   pwm_lk_timebase #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .enable(en_w), .clk_sel(clk_sel),
      .per_stg(per_stg), .per_apply(per_apply), .duty_stg(duty_stg),
      .duty_apply(duty_apply), .tick(tick), .load(load_req), .raw(raw),
      .per_act(per_act), .duty_act(duty_act), .irq(period_irq)
   );

   pwm_lk_deadband #(.DT_W(DT_W), .OUT_REG(OUT_REG)) u_db (
      .clk(clk), .rst_n(rst_n), .enable(en_w), .single(single_w),
      .tick(tick), .raw(raw), .dt_val(dt_val),
      .pwm_a(pwm_a), .pwm_b(pwm_b)
   );
endmodule

// File: rtl/pwm_lk_chk.sv
module pwm_lk_chk #(
   parameter int CNT_W = 12,
   parameter int DT_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       wr_addr,
   input logic             unlocked,
   input logic             en_w,
   input logic             single_w,
   input logic [CNT_W-1:0] per_stg,
   input logic [CNT_W-1:0] duty_stg,
   input logic [CNT_W-1:0] per_act,
   input logic [CNT_W-1:0] duty_act,
   input logic [DT_W-1:0]  dt_val,
   input logic             load_req,
   input logic             pwm_a,
   input logic             pwm_b,
   input logic             period_irq
);
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_a && pwm_b)); // R8

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !unlocked && wr_addr != 3'd0) |=>
      ($stable(en_w) && $stable(single_w) && $stable(dt_val) &&
       $stable(per_stg) && $stable(duty_stg))); // R2

   AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(duty_act) || !$stable(per_act)) |-> $past(load_req)); // R5

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_w && $past(!en_w)) |-> (!pwm_a && !pwm_b && !period_irq)); // R11

   AST_SINGLE_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (single_w && $past(single_w)) |-> !pwm_b); // R9
endmodule

bind pwm_lk_top pwm_lk_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .unlocked(unlocked), .en_w(en_w), .single_w(single_w),
   .per_stg(per_stg), .duty_stg(duty_stg), .per_act(per_act),
   .duty_act(duty_act), .dt_val(dt_val), .load_req(load_req),
   .pwm_a(pwm_a), .pwm_b(pwm_b), .period_irq(period_irq)
);

// File: tb/tb_pwm_lk_top.sv
module tb_pwm_lk_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] clk_sel = '0;
   logic       pwm_a, pwm_b, period_irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_lk_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clk_sel(clk_sel), .pwm_a(pwm_a), .pwm_b(pwm_b),
      .period_irq(period_irq)
   );

   // sel, period, duty, dead, expected a-high, expected b-high
   localparam int NV = 9;
   localparam int VEC [NV][6] = '{
      '{0,  20,   8,  2,   6,  10},
      '{0,  20,   0,  3,   0,  20},
      '{0,  20,  20,  3,  20,   0},
      '{0,  20,  25,  0,  20,   0},
      '{1,  16,   5,  1,   8,  20},
      '{0, 300, 150, 10, 140, 140},
      '{0,  20,   2,  5,   0,  13},
      '{2,  10,   3,  0,  12,  28},
      '{0,   1,   0,  0,   0,   1}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_irq();
      int n = 0;
      @(negedge clk);
      while (!period_irq && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (!period_irq) check("R6", "irq timeout", 0, 1);
   endtask

   task automatic measure(input int win, output int ca, output int cb, output int ci);
      ca = 0; cb = 0; ci = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         ca += int'(pwm_a); cb += int'(pwm_b); ci += int'(period_irq);
      end
   endtask

   task automatic setcfg(input int sel, input int p, input int d, input int dt);
      wr(0, 8'h55);
      wr(2, p & 255); wr(3, p >> 8);
      wr(4, d & 255); wr(5, d >> 8);
      wr(6, dt);
      clk_sel = 2'(sel);
      for (int k = 0; k < 3; k++) wait_irq();
   endtask

   task automatic run_window(input string req, input int win, input int ea, input int eb);
      int ca, cb, ci;
      wait_irq();
      measure(win, ca, cb, ci);
      check(req, "a-high", ca, ea);
      check(req, "b-high", cb, eb);
      check("R6", "irq per period", ci, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check("WD", "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int ca, cb, ci;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "pwm_a", int'(pwm_a), 0);
      check("R1", "pwm_b", int'(pwm_b), 0);
      check("R1", "irq", int'(period_irq), 0);
      // R11: disabled after reset, outputs quiet
      measure(40, ca, cb, ci);
      check("R11", "idle a+b+irq", ca + cb + ci, 0);

      // R3: unlock and enable complementary mode
      wr(0, 8'h55);
      wr(1, 1);
      // R7 R8 R10: table walk
      for (int v = 0; v < NV; v++) begin
         setcfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
         run_window("R7/R8/R10", VEC[v][1] << VEC[v][0], VEC[v][4], VEC[v][5]);
      end

      // R2: locked writes have no effect
      setcfg(0, 20, 8, 2);
      wr(0, 8'h54);
      wr(4, 12); wr(5, 0); wr(6, 0); wr(1, 0);
      for (int k = 0; k < 3; k++) wait_irq();
      run_window("R2", 20, 6, 10);

      // R4: low byte alone does nothing, high byte completes it
      wr(0, 8'h55);
      wr(4, 12);
      for (int k = 0; k < 3; k++) wait_irq();
      run_window("R4", 20, 6, 10);
      wr(5, 0);
      for (int k = 0; k < 3; k++) wait_irq();
      run_window("R4", 20, 10, 6);

      // R5: a completed duty waits for the period end
      setcfg(0, 20, 10, 0);
      wr(4, 15);
      wait_irq();
      wr(5, 0);
      measure(16, ca, cb, ci);
      check("R5", "old duty kept mid-period", ca, 9);
      for (int k = 0; k < 3; k++) wait_irq();
      run_window("R5", 20, 15, 5);

      // R9: single-output mode
      setcfg(0, 20, 8, 2);
      wr(1, 3);
      for (int k = 0; k < 2; k++) wait_irq();
      run_window("R9", 20, 8, 0);

      // R11: disable while running
      wr(1, 0);
      @(negedge clk);
      measure(50, ca, cb, ci);
      check("R11", "disabled a", ca, 0);
      check("R11", "disabled b", cb, 0);
      check("R11", "disabled irq", ci, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule